// File: doc/BRIEF.md
# Machine and Supervisor Control Register File

This block holds the privileged status, interrupt-enable, interrupt-pending, interrupt-delegation and trap-handling control registers of a processor hart. It serves two access levels, machine and supervisor. It has one combinational read port and one write port that is applied on the clock edge. Both ports are addressed by the standard 12-bit control-register number.

Each register accepts only its legal bits, and some fields accept only legal encodings. A write with an illegal encoding leaves the previous value of that field in place. The supervisor status, pending and enable registers have no storage of their own. They are masked windows onto the machine registers, and the pending and enable windows are filtered by the interrupt-delegation mask.

The summary-dirty flag in the top bit of both status views is computed from the floating-point and extension state fields each time it is read; it is never stored. A write that changes any field affecting address translation raises a one-cycle translation-flush pulse. A read of an address the block does not implement raises an illegal-access flag.

Top module: `csr_file`

## Requirements
- R1: After reset every register is zero, so reads of status (0x300), enable (0x304), pending (0x344), delegation (0x303) and machine trap vector (0x305) return 0.
- R2: A write to machine status (0x300) updates only these bits: 1 (supervisor interrupt enable), 3 (machine interrupt enable), 5 (supervisor prior enable), 7 (machine prior enable), 8 (supervisor previous privilege), 14:13 (FP state), 17 (modify-privilege) and 18 (user-memory protect). Bits 16:15 (extension state) are also writable when the HAS_EXT parameter is 1. Every other bit below the top bit reads 0.
- R3: Machine previous privilege, bits 12:11, updates only when the written value is 0, 1 or 3. A written value of 2 leaves the field unchanged.
- R4: The translation-mode field, bits 28:24, updates only with a legal code. Code 0 is always legal. With XLEN=64, codes 9 and 10 are legal. With XLEN=32, code 8 is legal. Any other code leaves the field unchanged.
- R5: Bit XLEN-1 of machine status and of supervisor status reads 1 exactly when bits 14:13 equal 3 or bits 16:15 equal 3.
- R6: Software can write only bits 1 and 5 of the pending register (0x344). The enable register (0x304) accepts bits 1, 3, 5, 7, 9 and 12.
- R7: The delegation register (0x303) accepts only bits 1, 5, 9 and 12.
- R8: Supervisor status (0x100) reads machine status masked to bits 1, 5, 8, 14:13, 16:15 and 18, plus the R5 flag. A write to it changes only those bits of machine status.
- R9: Supervisor pending (0x144) and supervisor enable (0x104) read as the machine register ANDed with the delegation register. A write through them changes only delegated bits of the machine register.
- R10: Writes to the machine trap vector (0x305) and the supervisor trap vector (0x105) store the low two bits as zero. The user counter-enable (0x320) and supervisor counter-enable (0x321) registers keep only their low 3 bits.
- R11: flushTlb is high for exactly the one cycle that follows a write edge, through either status view, that changes bits 28:24, 12:11, 17 or 18. It stays low after a status write that changes none of them.
- R12: A read of an unimplemented address sets rdIllegal and returns 0. A write to such an address changes no register.
- R13: The scratch, exception-PC and cause registers (machine 0x340/0x341/0x342, supervisor 0x140/0x141/0x142) hold all XLEN written bits. Writes take effect on the clock edge, and reads are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rdAddr | input | 12 | Read register number |
| rdData | output | XLEN | Read value (combinational) |
| rdIllegal | output | 1 | Read address not implemented |
| wrEn | input | 1 | Write strobe |
| wrAddr | input | 12 | Write register number |
| wrData | input | XLEN | Write value |
| flushTlb | output | 1 | One-cycle translation-flush pulse |

## Verification
The assertions assume that wrEn is only ever 0 or 1 and that the address buses are never unknown. They also assume that each write is held for a single clock edge, because the flush check ties each pulse to the write edge just before it. The bench drives every input on the falling edge and raises wrEn for exactly one edge per write. It reads results back through rdAddr once the write edge has passed, so the stimulus stays within those limits.

// File: rtl/csr_file_pkg.sv
package csr_file_pkg;

  localparam logic [11:0] ADR_SSTATUS = 12'h100;
  localparam logic [11:0] ADR_SIE     = 12'h104;
  localparam logic [11:0] ADR_STVEC   = 12'h105;
  localparam logic [11:0] ADR_SSCR    = 12'h140;
  localparam logic [11:0] ADR_SEPC    = 12'h141;
  localparam logic [11:0] ADR_SCAUSE  = 12'h142;
  localparam logic [11:0] ADR_SIP     = 12'h144;
  localparam logic [11:0] ADR_MSTATUS = 12'h300;
  localparam logic [11:0] ADR_DELEG   = 12'h303;
  localparam logic [11:0] ADR_MIE     = 12'h304;
  localparam logic [11:0] ADR_MTVEC   = 12'h305;
  localparam logic [11:0] ADR_UCEN    = 12'h320;
  localparam logic [11:0] ADR_SCEN    = 12'h321;
  localparam logic [11:0] ADR_MSCR    = 12'h340;
  localparam logic [11:0] ADR_MEPC    = 12'h341;
  localparam logic [11:0] ADR_MCAUSE  = 12'h342;
  localparam logic [11:0] ADR_MIP     = 12'h344;

  // status field masks (low 32 bits)
  localparam logic [31:0] ST_BASE  = 32'h0006_61AA; // SIE,MIE,SPIE,MPIE,SPP,FS,MPRV,PUM
  localparam logic [31:0] ST_XS    = 32'h0001_8000;
  localparam logic [31:0] ST_MPP   = 32'h0000_1800;
  localparam logic [31:0] ST_VM    = 32'h1F00_0000;
  localparam logic [31:0] ST_SVIEW = 32'h0005_E122; // supervisor window
  localparam logic [31:0] ST_FLUSH = 32'h1F06_1800; // VM,MPP,MPRV,PUM

  // interrupt bit masks
  localparam logic [31:0] IRQ_SW    = 32'h0000_0022;
  localparam logic [31:0] IRQ_DELEG = 32'h0000_1222;
  localparam logic [31:0] IRQ_ALL   = 32'h0000_12AA;

  typedef enum logic [4:0] {
    SEL_NONE, SEL_MSTATUS, SEL_SSTATUS, SEL_MIP, SEL_SIP, SEL_MIE, SEL_SIE,
    SEL_DELEG, SEL_MTVEC, SEL_STVEC, SEL_MEPC, SEL_SEPC, SEL_MSCR, SEL_SSCR,
    SEL_MCAUSE, SEL_SCAUSE, SEL_UCEN, SEL_SCEN
  } rdSel_e;

  typedef struct packed {
    logic status;
    logic sview;
    logic mip;
    logic sip;
    logic mie;
    logic sie;
    logic deleg;
    logic mtvec;
    logic stvec;
    logic mepc;
    logic sepc;
    logic mscr;
    logic sscr;
    logic mcause;
    logic scause;
    logic ucen;
    logic scen;
  } wrStrobe_t;

endpackage

// File: rtl/csr_file_ctrl.sv
module csr_file_ctrl
  import csr_file_pkg::*;
(
  input  logic       wrEn,
  input  logic [11:0] wrAddr,
  input  logic [11:0] rdAddr,
  output wrStrobe_t  stb,
  output rdSel_e     rdSel,
  output logic       rdIllegal
);

  always_comb begin
    stb = '0;
    if (wrEn) begin
      unique case (wrAddr)
        ADR_MSTATUS: stb.status = 1'b1;
        ADR_SSTATUS: stb.sview  = 1'b1;
        ADR_MIP:     stb.mip    = 1'b1;
        ADR_SIP:     stb.sip    = 1'b1;
        ADR_MIE:     stb.mie    = 1'b1;
        ADR_SIE:     stb.sie    = 1'b1;
        ADR_DELEG:   stb.deleg  = 1'b1;
        ADR_MTVEC:   stb.mtvec  = 1'b1;
        ADR_STVEC:   stb.stvec  = 1'b1;
        ADR_MEPC:    stb.mepc   = 1'b1;
        ADR_SEPC:    stb.sepc   = 1'b1;
        ADR_MSCR:    stb.mscr   = 1'b1;
        ADR_SSCR:    stb.sscr   = 1'b1;
        ADR_MCAUSE:  stb.mcause = 1'b1;
        ADR_SCAUSE:  stb.scause = 1'b1;
        ADR_UCEN:    stb.ucen   = 1'b1;
        ADR_SCEN:    stb.scen   = 1'b1;
        default:     stb = '0;
      endcase
    end
  end

  always_comb begin
    unique case (rdAddr)
      ADR_MSTATUS: rdSel = SEL_MSTATUS;
      ADR_SSTATUS: rdSel = SEL_SSTATUS;
      ADR_MIP:     rdSel = SEL_MIP;
      ADR_SIP:     rdSel = SEL_SIP;
      ADR_MIE:     rdSel = SEL_MIE;
      ADR_SIE:     rdSel = SEL_SIE;
      ADR_DELEG:   rdSel = SEL_DELEG;
      ADR_MTVEC:   rdSel = SEL_MTVEC;
      ADR_STVEC:   rdSel = SEL_STVEC;
      ADR_MEPC:    rdSel = SEL_MEPC;
      ADR_SEPC:    rdSel = SEL_SEPC;
      ADR_MSCR:    rdSel = SEL_MSCR;
      ADR_SSCR:    rdSel = SEL_SSCR;
      ADR_MCAUSE:  rdSel = SEL_MCAUSE;
      ADR_SCAUSE:  rdSel = SEL_SCAUSE;
      ADR_UCEN:    rdSel = SEL_UCEN;
      ADR_SCEN:    rdSel = SEL_SCEN;
      default:     rdSel = SEL_NONE;
    endcase
    rdIllegal = (rdSel == SEL_NONE);
  end

endmodule

// File: rtl/csr_file_dp.sv
module csr_file_dp
  import csr_file_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter bit HAS_EXT = 1'b1
) (
  input  logic            clk,
  input  logic            rstN,
  input  wrStrobe_t       stb,
  input  logic [XLEN-1:0] wrData,
  input  rdSel_e          rdSel,
  output logic [XLEN-1:0] rdData,
  output logic            flushTlb
);

  localparam logic [XLEN-1:0] M_BASE  = XLEN'(ST_BASE);
  localparam logic [XLEN-1:0] M_XS    = HAS_EXT ? XLEN'(ST_XS) : '0;
  localparam logic [XLEN-1:0] M_MPP   = XLEN'(ST_MPP);
  localparam logic [XLEN-1:0] M_VM    = XLEN'(ST_VM);
  localparam logic [XLEN-1:0] M_SVIEW = XLEN'(ST_SVIEW);
  localparam logic [XLEN-1:0] M_FLUSH = XLEN'(ST_FLUSH);
  localparam logic [XLEN-1:0] M_SW    = XLEN'(IRQ_SW);
  localparam logic [XLEN-1:0] M_DELEG = XLEN'(IRQ_DELEG);
  localparam logic [XLEN-1:0] M_ALL   = XLEN'(IRQ_ALL);
  localparam logic [XLEN-1:0] M_ALIGN = ~XLEN'(3);

  logic [XLEN-1:0] status, mip, mie, deleg, mtvec, stvec;
  logic [XLEN-1:0] mepc, sepc, mscr, sscr, mcause, scause;
  logic [2:0]      ucen, scen;
  logic            flushQ;

  logic [XLEN-1:0] statusSrc, statusMask, statusNext, mipSrc, mieSrc, sdBit;
  logic            statusWr, vmOk, mppOk, dirty;

  assign statusWr  = stb.status | stb.sview;
  assign statusSrc = stb.sview ? ((status & ~M_SVIEW) | (wrData & M_SVIEW)) : wrData;
  assign mppOk     = (statusSrc[12:11] != 2'b10);

  generate
    if (XLEN == 64) begin : g_vm64
      assign vmOk = (statusSrc[28:24] == 5'd0) || (statusSrc[28:24] == 5'd9) ||
                    (statusSrc[28:24] == 5'd10);
    end else begin : g_vm32
      assign vmOk = (statusSrc[28:24] == 5'd0) || (statusSrc[28:24] == 5'd8);
    end
  endgenerate

  assign statusMask = M_BASE | M_XS | (vmOk ? M_VM : '0) | (mppOk ? M_MPP : '0);
  assign statusNext = (status & ~statusMask) | (statusSrc & statusMask);

  assign mipSrc = stb.sip ? ((mip & ~deleg) | (wrData & deleg)) : wrData;
  assign mieSrc = stb.sie ? ((mie & ~deleg) | (wrData & deleg)) : wrData;

  assign dirty = (status[14:13] == 2'b11) || (status[16:15] == 2'b11);
  assign sdBit = {dirty, {(XLEN-1){1'b0}}};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      status <= '0; mip <= '0; mie <= '0; deleg <= '0;
      mtvec <= '0; stvec <= '0; mepc <= '0; sepc <= '0;
      mscr <= '0; sscr <= '0; mcause <= '0; scause <= '0;
      ucen <= '0; scen <= '0; flushQ <= 1'b0;
    end else begin
      flushQ <= statusWr && (((statusNext ^ status) & M_FLUSH) != '0);
      if (statusWr)          status <= statusNext;
      if (stb.mip | stb.sip) mip    <= mipSrc & M_SW;
      if (stb.mie | stb.sie) mie    <= mieSrc & M_ALL;
      if (stb.deleg)         deleg  <= wrData & M_DELEG;
      if (stb.mtvec)         mtvec  <= wrData & M_ALIGN;
      if (stb.stvec)         stvec  <= wrData & M_ALIGN;
      if (stb.mepc)          mepc   <= wrData;
      if (stb.sepc)          sepc   <= wrData;
      if (stb.mscr)          mscr   <= wrData;
      if (stb.sscr)          sscr   <= wrData;
      if (stb.mcause)        mcause <= wrData;
      if (stb.scause)        scause <= wrData;
      if (stb.ucen)          ucen   <= wrData[2:0];
      if (stb.scen)          scen   <= wrData[2:0];
    end
  end

  assign flushTlb = flushQ;

  always_comb begin
    unique case (rdSel)
      SEL_MSTATUS: rdData = status | sdBit;
      SEL_SSTATUS: rdData = (status & M_SVIEW) | sdBit;
      SEL_MIP:     rdData = mip;
      SEL_SIP:     rdData = mip & deleg;
      SEL_MIE:     rdData = mie;
      SEL_SIE:     rdData = mie & deleg;
      SEL_DELEG:   rdData = deleg;
      SEL_MTVEC:   rdData = mtvec;
      SEL_STVEC:   rdData = stvec;
      SEL_MEPC:    rdData = mepc;
      SEL_SEPC:    rdData = sepc;
      SEL_MSCR:    rdData = mscr;
      SEL_SSCR:    rdData = sscr;
      SEL_MCAUSE:  rdData = mcause;
      SEL_SCAUSE:  rdData = scause;
      SEL_UCEN:    rdData = XLEN'(ucen);
      SEL_SCEN:    rdData = XLEN'(scen);
      default:     rdData = '0;
    endcase
  end

  a_r3_mpp_reserved: assert property (@(posedge clk) disable iff (!rstN)
    (statusWr && statusSrc[12:11] == 2'b10) |=> (status[12:11] == $past(status[12:11])));
  a_r6_pending_bits: assert property (@(posedge clk) disable iff (!rstN)
    ((mip & ~M_SW) == '0) && ((mie & ~M_ALL) == '0));
  a_r7_deleg_bits: assert property (@(posedge clk) disable iff (!rstN)
    (deleg & ~M_DELEG) == '0);
  a_r10_vec_align: assert property (@(posedge clk) disable iff (!rstN)
    (mtvec[1:0] == 2'b00) && (stvec[1:0] == 2'b00));
  a_r11_flush_after_write: assert property (@(posedge clk) disable iff (!rstN)
    flushTlb |-> $past(statusWr));
  a_r13_no_write_hold: assert property (@(posedge clk) disable iff (!rstN)
    (stb == '0) |=> ($stable(status) && $stable(mscr) && $stable(mie)));

endmodule

// File: rtl/csr_file.sv
module csr_file
  import csr_file_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter bit HAS_EXT = 1'b1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [11:0]     rdAddr,
  output logic [XLEN-1:0] rdData,
  output logic            rdIllegal,
  input  logic            wrEn,
  input  logic [11:0]     wrAddr,
  input  logic [XLEN-1:0] wrData,
  output logic            flushTlb
);

  wrStrobe_t stb;
  rdSel_e    rdSel;

  csr_file_ctrl u_ctrl (
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .rdAddr    (rdAddr),
    .stb       (stb),
    .rdSel     (rdSel),
    .rdIllegal (rdIllegal)
  );

  csr_file_dp #(.XLEN(XLEN), .HAS_EXT(HAS_EXT)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .wrData   (wrData),
    .rdSel    (rdSel),
    .rdData   (rdData),
    .flushTlb (flushTlb)
  );

  a_r12_illegal_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    rdIllegal |-> (rdData == '0));

endmodule

// File: tb/csr_file_test.sv
module csr_file_test;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 64;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [11:0]     rdAddr = '0;
  logic [XLEN-1:0] rdData;
  logic            rdIllegal;
  logic            wrEn = 1'b0;
  logic [11:0]     wrAddr = '0;
  logic [XLEN-1:0] wrData = '0;
  logic            flushTlb;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  csr_file #(.XLEN(XLEN), .HAS_EXT(1'b1)) uut (
    .clk(clk), .rstN(rstN), .rdAddr(rdAddr), .rdData(rdData), .rdIllegal(rdIllegal),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .flushTlb(flushTlb)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [XLEN-1:0] got, input logic [XLEN-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [XLEN-1:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rdChk(input string req, input logic [11:0] a, input logic [XLEN-1:0] exp);
    rdAddr = a;
    #1;
    check(req, rdData, exp);
  endtask

  task automatic testReset();
    rdChk("R1 status", 12'h300, '0);
    rdChk("R1 enable", 12'h304, '0);
    rdChk("R1 pending", 12'h344, '0);
    rdChk("R1 deleg", 12'h303, '0);
    rdChk("R1 mtvec", 12'h305, '0);
    check("R1 flush", 64'(flushTlb), 64'd0);
  endtask

  task automatic testStatusMask();
    wr(12'h300, '1);
    check("R11 flush on change", 64'(flushTlb), 64'd1);
    rdChk("R2 R5 status ones", 12'h300, 64'h8000_0000_0007_F9AA);
    wr(12'h300, 64'h1000);
    rdChk("R3 reserved mpp kept", 12'h300, 64'h1800);
    wr(12'h300, 64'h0000_0000_0000_0000);
    rdChk("R3 mpp zero legal", 12'h300, 64'h0);
  endtask

  task automatic testVm();
    wr(12'h300, 64'h0900_0000);
    check("R11 flush vm", 64'(flushTlb), 64'd1);
    rdChk("R4 code 9", 12'h300, 64'h0900_0000);
    wr(12'h300, 64'h0800_0000);
    check("R11 no flush unchanged", 64'(flushTlb), 64'd0);
    rdChk("R4 code 8 refused", 12'h300, 64'h0900_0000);
    wr(12'h300, 64'h0A00_0000);
    rdChk("R4 code 10", 12'h300, 64'h0A00_0000);
    wr(12'h300, 64'h0);
    rdChk("R4 code 0", 12'h300, 64'h0);
    @(negedge clk);
    check("R11 pulse one cycle", 64'(flushTlb), 64'd0);
  endtask

  task automatic testDirty();
    wr(12'h300, 64'h1_8000);
    rdChk("R5 xs dirty", 12'h300, 64'h8000_0000_0001_8000);
    rdChk("R5 R8 sview dirty", 12'h100, 64'h8000_0000_0001_8000);
    wr(12'h300, 64'h0000_8000);
    rdChk("R5 not dirty", 12'h300, 64'h8000);
  endtask

  task automatic testSview();
    wr(12'h300, '1);
    rdChk("R8 sview read", 12'h100, 64'h8000_0000_0005_E122);
    wr(12'h100, 64'h0);
    check("R11 flush via sview", 64'(flushTlb), 64'd1);
    rdChk("R8 machine bits kept", 12'h300, 64'h0002_1888);
    rdChk("R8 sview cleared", 12'h100, 64'h0);
  endtask

  task automatic testIrq();
    wr(12'h344, '1);
    rdChk("R6 pending", 12'h344, 64'h22);
    wr(12'h304, '1);
    rdChk("R6 enable", 12'h304, 64'h12AA);
    wr(12'h303, '1);
    rdChk("R7 deleg", 12'h303, 64'h1222);
    wr(12'h303, 64'h2);
    rdChk("R9 sip view", 12'h144, 64'h2);
    rdChk("R9 sie view", 12'h104, 64'h2);
    wr(12'h144, 64'h0);
    rdChk("R9 sip write", 12'h344, 64'h20);
    wr(12'h104, 64'h0);
    rdChk("R9 sie write", 12'h304, 64'h12A8);
  endtask

  task automatic testVecCen();
    wr(12'h305, '1);
    rdChk("R10 mtvec", 12'h305, 64'hFFFF_FFFF_FFFF_FFFC);
    wr(12'h105, 64'h1235);
    rdChk("R10 stvec", 12'h105, 64'h1234);
    wr(12'h320, 64'hFF);
    rdChk("R10 ucen", 12'h320, 64'h7);
    wr(12'h321, 64'h5A);
    rdChk("R10 scen", 12'h321, 64'h2);
  endtask

  task automatic testFull();
    wr(12'h340, 64'hDEAD_BEEF_1234_5678);
    rdChk("R13 mscratch", 12'h340, 64'hDEAD_BEEF_1234_5678);
    wr(12'h141, 64'h8000_0000_0000_0001);
    rdChk("R13 sepc", 12'h141, 64'h8000_0000_0000_0001);
    wr(12'h342, 64'h8000_0000_0000_0007);
    rdChk("R13 mcause", 12'h342, 64'h8000_0000_0000_0007);
  endtask

  task automatic testIllegal();
    rdAddr = 12'h7FF; #1;
    check("R12 flag", 64'(rdIllegal), 64'd1);
    check("R12 data", rdData, 64'h0);
    wr(12'h7FF, '1);
    rdChk("R12 write ignored", 12'h340, 64'hDEAD_BEEF_1234_5678);
    check("R12 legal flag", 64'(rdIllegal), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testStatusMask();
    testVm();
    testDirty();
    testSview();
    testIrq();
    testVecCen();
    testFull();
    testIllegal();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule